// File: doc/BRIEF.md
# Dual-Chain Serial DAC Loader

This block writes configuration words into two daisy-chained strings of serial DACs. The two strings share one data wire and one clock wire. Each string has its own active-low select. The wide string holds four dual 12-bit converters and takes a 64-bit frame per pass (four 16-bit words). The narrow string holds two quad 8-bit converters and takes a 24-bit frame per pass (two 12-bit words). A full card load is six frames: the wide frame twice and the narrow frame four times. The loader carries out one frame per request. The caller issues the six requests in turn.

A frame enters through a valid/ready port. The port carries a chain flag and a word. For a narrow frame the payload is the low 24 bits of the word. The loader is ready only when idle. A frame is taken on a clock where `in_valid` and `in_ready` are both high. The sender must hold the frame and `in_valid` until that clock. A `in_valid` raised while the loader is busy does nothing.

Every step of the wire sequence lasts one half-step of `TICK_DIV` clocks, so slow hand-driven timing can be matched. The sequence for a frame of N bits is as follows:
- One select-setup half-step.
- Two half-steps per bit: data with the clock low, then the clock high with the data held.
- One half-step that returns the clock low.
- One half-step with the select released.
- A single-cycle done pulse.

Top module: `dac_chain_loader`

## Requirements
- R1: When idle (and during reset) `in_ready`=1, `sclk`=0, `sdat`=0, `cs_wide_n`=1, `cs_narrow_n`=1 and `done`=0.
- R2: A frame is accepted on a rising clock edge where `in_valid`=1 and `in_ready`=1. `in_ready` is 0 from the next cycle until the loader is idle again. While busy, `in_valid` and the frame inputs have no effect on any output.
- R3: `in_chain`=0 selects the wide chain, so only `cs_wide_n` goes low. `in_chain`=1 selects the narrow chain, so only `cs_narrow_n` goes low. The two selects are never low together.
- R4: In the first `TICK_DIV` cycles after acceptance, the chosen select is low and both `sclk` and `sdat` are 0.
- R5: Each bit takes 2·`TICK_DIV` cycles. For the first `TICK_DIV` cycles `sdat` shows the bit with `sclk`=0. For the next `TICK_DIV` cycles `sclk`=1 with the same `sdat`.
- R6: Bits leave MSB first. A wide frame sends `in_word[63:0]`, starting at bit 63. A narrow frame sends `in_word[23:0]`, starting at bit 23, and `in_word[63:24]` is ignored.
- R7: After the last bit's clock-high half-step there is one half-step with `sclk`=0, `sdat` still holding the last bit, and the select still low.
- R8: Next, both selects are high for `TICK_DIV` cycles with `sclk`=`sdat`=0. Then `done` is 1 for exactly one cycle with `in_ready`=0, and the loader is idle on the following cycle.
- R9: The select stays low for exactly `TICK_DIV`·(2N+2) consecutive cycles per frame, where N is 64 or 24.
- R10: `sdat` never changes on a cycle where `sclk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame request valid |
| in_ready | output | 1 | Loader idle and able to take a frame |
| in_chain | input | 1 | 0 = wide chain, 1 = narrow chain |
| in_word | input | WIDE_BITS | Frame payload; the narrow chain uses the low NARROW_BITS bits |
| sdat | output | 1 | Shared serial data |
| sclk | output | 1 | Shared serial clock |
| cs_wide_n | output | 1 | Active-low select of the wide chain |
| cs_narrow_n | output | 1 | Active-low select of the narrow chain |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the loader with `TICK_DIV`=3 and the default frame widths of 64 and 24 bits. A half-step longer than one cycle lets the check catch a miscounted tick, a half-step that is too short or too long, and a select released one phase early. The full frame lengths bring within reach the last-bit tail and the alignment of the narrow payload within the word. Back-to-back requests and requests made while busy exercise the handshake at the exact cycle the loader returns to idle.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_LO, ST_HI, ST_TAIL, ST_REL, ST_DONE
  } ldr_state_e;

  typedef enum logic {
    CH_WIDE   = 1'b0,
    CH_NARROW = 1'b1
  } chain_e;
endpackage

// File: rtl/dcl_tick_gen.sv
module dcl_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dcl_frame_shifter.sv
module dcl_frame_shifter #(
  parameter int WIDE_BITS   = 64,
  parameter int NARROW_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 sel_narrow,
  input  logic [WIDE_BITS-1:0] word,
  input  logic                 shift,
  output logic                 msb
);
  logic [WIDE_BITS-1:0] aligned;
  logic [WIDE_BITS-1:0] shreg;

  generate
    if (NARROW_BITS < WIDE_BITS) begin : g_pad
      assign aligned = sel_narrow
        ? {word[NARROW_BITS-1:0], {(WIDE_BITS-NARROW_BITS){1'b0}}}
        : word;
    end else begin : g_same
      assign aligned = word;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= aligned;
    else if (shift) shreg <= {shreg[WIDE_BITS-2:0], 1'b0};
  end

  assign msb = shreg[WIDE_BITS-1];
endmodule

// File: rtl/dcl_seq_ctrl.sv
module dcl_seq_ctrl
  import dcl_pkg::*;
#(
  parameter int WIDE_BITS   = 64,
  parameter int NARROW_BITS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sel_narrow,
  input  logic       tick,
  output ldr_state_e state,
  output chain_e     chain,
  output logic       shift,
  output logic       run
);
  localparam int BW = $clog2(WIDE_BITS + 1);
  localparam logic [BW-1:0] N_WIDE   = BW'(WIDE_BITS);
  localparam logic [BW-1:0] N_NARROW = BW'(NARROW_BITS);

  logic [BW-1:0] bits_left;
  logic          last_bit;

  assign last_bit = (bits_left == BW'(1));
  assign run      = (state != ST_IDLE) && (state != ST_DONE);
  assign shift    = tick && (state == ST_HI) && !last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chain     <= CH_WIDE;
      bits_left <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SEL;
          chain     <= sel_narrow ? CH_NARROW : CH_WIDE;
          bits_left <= sel_narrow ? N_NARROW : N_WIDE;
        end
        ST_SEL:  if (tick) state <= ST_LO;
        ST_LO:   if (tick) state <= ST_HI;
        ST_HI:   if (tick) begin
          if (last_bit) state <= ST_TAIL;
          else begin
            state     <= ST_LO;
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_TAIL: if (tick) state <= ST_REL;
        ST_REL:  if (tick) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dcl_pkg::*;
#(
  parameter int WIDE_BITS   = 64,
  parameter int NARROW_BITS = 24,
  parameter int TICK_DIV    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_chain,
  input  logic [WIDE_BITS-1:0] in_word,
  output logic                 sdat,
  output logic                 sclk,
  output logic                 cs_wide_n,
  output logic                 cs_narrow_n,
  output logic                 done
);
  ldr_state_e state;
  chain_e     chain;
  logic       tick, run, shift, start, msb, cs_active, data_phase;

  assign in_ready = (state == ST_IDLE);
  assign start    = in_valid && in_ready;

  dcl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dcl_seq_ctrl #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_narrow(in_chain),
    .tick(tick), .state(state), .chain(chain), .shift(shift), .run(run)
  );

  dcl_frame_shifter #(.WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .sel_narrow(in_chain),
    .word(in_word), .shift(shift), .msb(msb)
  );

  assign cs_active  = (state == ST_SEL) || (state == ST_LO) ||
                      (state == ST_HI)  || (state == ST_TAIL);
  assign data_phase = (state == ST_LO) || (state == ST_HI) || (state == ST_TAIL);

  assign sdat        = data_phase && msb;
  assign sclk        = (state == ST_HI);
  assign cs_wide_n   = !(cs_active && (chain == CH_WIDE));
  assign cs_narrow_n = !(cs_active && (chain == CH_NARROW));
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/dac_chain_loader_chk.sv
module dac_chain_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sdat,
  input logic sclk,
  input logic cs_wide_n,
  input logic cs_narrow_n,
  input logic done
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!sclk && !sdat && cs_wide_n && cs_narrow_n && !done));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_not_ready_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_wide_n || !cs_narrow_n) |-> !in_ready);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_wide_n && !cs_narrow_n));

  p_select_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_wide_n) || $fell(cs_narrow_n)) |-> (!sclk && !sdat));

  p_release_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_wide_n) || $rose(cs_narrow_n)) |-> (!sclk && !$past(sclk)));

  p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_wide_n && cs_narrow_n && $past(cs_wide_n) && $past(cs_narrow_n) && !in_ready));

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdat));
endmodule

bind dac_chain_loader dac_chain_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sdat(sdat), .sclk(sclk), .cs_wide_n(cs_wide_n),
  .cs_narrow_n(cs_narrow_n), .done(done)
);

// File: tb/sim_dac_chain_loader.sv
module sim_dac_chain_loader;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 3;
  localparam int WB = 64;
  localparam int NB = 24;
  localparam logic [5:0] IDLE_V = 6'b110001; // {csw,csn,sclk,sdat,done,ready}

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_chain = 1'b0;
  logic [WB-1:0] in_word = '0;
  logic          in_ready, sdat, sclk, cs_wide_n, cs_narrow_n, done;

  int n_chk = 0;
  int n_fail = 0;
  int run_len = 0;
  int exp_run = 0;
  logic [5:0] q_exp[$];
  int         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_loader #(.WIDE_BITS(WB), .NARROW_BITS(NB), .TICK_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chain(in_chain), .in_word(in_word), .sdat(sdat), .sclk(sclk),
    .cs_wide_n(cs_wide_n), .cs_narrow_n(cs_narrow_n), .done(done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    summary();
    $finish;
  end

  task automatic push(int n, logic [5:0] v, int tag);
    for (int i = 0; i < n; i++) begin
      q_exp.push_back(v);
      q_tag.push_back(tag);
    end
  endtask

  task automatic push_frame(logic ch, logic [WB-1:0] w);
    int  n;
    logic cw, cn, b;
    n  = ch ? NB : WB;
    cw = ch;
    cn = !ch;
    exp_run = D * (2 * n + 2);                       // R9
    push(D, {cw, cn, 1'b0, 1'b0, 1'b0, 1'b0}, 4);    // R4 select setup
    for (int i = n - 1; i >= 0; i--) begin            // R6 MSB first
      b = w[i];
      push(D, {cw, cn, 1'b0, b, 1'b0, 1'b0}, 5);     // R5 data, clock low
      push(D, {cw, cn, 1'b1, b, 1'b0, 1'b0}, 5);     // R5 clock high
    end
    push(D, {cw, cn, 1'b0, w[0], 1'b0, 1'b0}, 7);    // R7 tail
    push(D, 6'b110000, 8);                           // R8 release
    push(1, 6'b110010, 8);                           // R8 done pulse
  endtask

  task automatic compare();
    logic [5:0] e, a;
    int tag;
    if (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      tag = q_tag.pop_front();
    end else begin
      e = IDLE_V;
      tag = 1;                                       // R1 idle
    end
    a = {cs_wide_n, cs_narrow_n, sclk, sdat, done, in_ready};
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL R%0d (R2 ready bit, R6 data bit): actual %b expected %b at %0t", tag, a, e, $time);
    end
    n_chk++;
    if (!cs_wide_n && !cs_narrow_n) begin
      n_fail++;
      $display("FAIL R3: both selects low, actual 00 expected one high at %0t", $time);
    end
    if (!cs_wide_n || !cs_narrow_n) run_len++;
    else if (run_len > 0) begin
      n_chk++;
      if (run_len != exp_run) begin
        n_fail++;
        $display("FAIL R9: select low for %0d cycles, expected %0d", run_len, exp_run);
      end
      run_len = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(logic ch, logic [WB-1:0] w);
    while (in_ready !== 1'b1) step();
    in_chain = ch;
    in_word  = w;
    in_valid = 1'b1;
    push_frame(ch, w);
    step();
    in_valid = 1'b0;
    in_word  = '0;
  endtask

  task automatic drain();
    while (q_exp.size() > 0) step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;                                         // R1 reset state
    if ({cs_wide_n, cs_narrow_n, sclk, sdat, done, in_ready} !== IDLE_V) begin
      n_fail++;
      $display("FAIL R1: reset outputs actual %b expected %b",
               {cs_wide_n, cs_narrow_n, sclk, sdat, done, in_ready}, IDLE_V);
    end
    rst_n = 1'b1;
    repeat (2) step();

    send(1'b0, 64'hA5C3_0F1E_8001_7FFE);             // R3 wide chain, mixed bits
    drain();
    send(1'b1, 64'hDEAD_BEEF_FF80_0001);             // R6 narrow, upper bits ignored
    drain();
    send(1'b1, 64'h0000_0000_005A_5A5A);
    send(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);             // R2 back-to-back request
    drain();

    send(1'b0, 64'h0000_0000_0000_0001);             // R7 last bit one held in tail
    repeat (10) step();
    in_valid = 1'b1;                                 // R2 request while busy ignored
    in_chain = 1'b1;
    in_word  = 64'h1234_5678_9ABC_DEF0;
    repeat (40) step();
    in_valid = 1'b0;
    in_word  = '0;
    drain();

    send(1'b1, 64'hFFFF_FFFF_FF00_0000);             // R6 narrow payload all zero
    drain();
    send(1'b1, 64'h0000_0000_0080_0001);             // R8 narrow end sequence
    drain();
    repeat (3) step();

    summary();
    $finish;
  end
endmodule